// File: doc/BRIEF.md
# Multi-Line Reset Controller with Per-Domain Confirmation

This block holds a bank of reset lines, each one feeding a logic region that runs on its own clock. Software puts a line into reset by writing 1 to that line's bit in one of a set of 32-bit hold registers, and takes it out of reset by writing 0. Each request crosses into the line's own clock domain before the line output moves. It then crosses back to the register clock before the matching status bit changes. A status bit that has moved therefore confirms that the target domain has taken up the new state. A region whose clock is stopped never confirms, and software detects this by polling.

Status bits normally read 0 while a line is held and 1 once it is released. A constant per-line mask picks out the few lines that report the other way round. The register bus takes 32-bit accesses, and also 64-bit accesses that cover two neighbouring registers. Read data returns one cycle after the request.

Top module: `reset_bank_ctrl`

## Requirements
- R1: After controller reset every hold bit is 1, every `line_rst` output is 1, and the status words read the held value of each line.
- R2: A write to the hold word at offset 0x00, 0x04, 0x08 or 0x0C sets line 32*m+n from bit n of word m, where m is the offset divided by 4. A 1 holds the line and a 0 releases it.
- R3: `line_rst[i]` takes the value of its hold bit on exactly the second rising edge of `dom_clk[i]` after that hold bit changes.
- R4: The status bit at offset 0x10 + 4*m, bit n, follows `line_rst[32m+n]` two `clk` edges later. For a line whose polarity bit is 0, it reads 0 while the line is held and 1 once the line is released.
- R5: A line whose bit in `POL_MASK` is 1 reports with the opposite polarity. The default mask sets lines 2, 17, 40 and 77, so after reset the four status words read 0x00020004, 0x00000100, 0x00002000 and 0x00000000.
- R6: While `dom_clk[i]` is stopped, neither `line_rst[i]` nor its status bit changes, whatever is written. Both catch up once the clock runs again.
- R7: Writes to the status offsets 0x10 to 0x1C have no effect on any hold bit or line.
- R8: Reads at offsets 0x20 and above return zero, and writes there change nothing.
- R9: With `req_wide`=1, one access covers the register at `req_addr` in bits 31:0 and the register at `req_addr`+4 in bits 63:32, for both reads and writes.
- R10: A hold word reads back the value last written to it.
- R11: `rd_valid` pulses for exactly one cycle, one cycle after each read request, and at no other time.
- R12: A full pulse works: a hold is written, its status confirms, a release is written straight after, and its status confirms again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low controller reset; it also clears the domain-side flops while their clocks run |
| dom_clk | input | NUM_LINES | One clock per line's target domain |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access covering two registers |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 64 | Write data; only bits 31:0 are used unless the access is wide |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 64 | Read data; the upper half is zero for a narrow read |
| line_rst | output | NUM_LINES | Reset lines, 1 = held; each bit is in its own `dom_clk` domain |

## Verification
A behavioural reference model follows the lines and the status bits on every clock. The bench exercises four kinds of write pattern. Whole-word releases show that line timing and status polarity agree across a full word. Mixed bit patterns in a word that holds a reversed-polarity line separate the two polarities within one status word. Wide writes and reads, set against narrow ones, show which half goes to which offset. Writes aimed at the status offsets and at unmapped offsets must leave every line alone. A gated domain clock must hold back both the line and its confirmation until the clock runs again, and a hold followed at once by a release on one line must confirm both edges.

// File: rtl/rstc_pkg.sv
// Shared widths for the reset bank: register word size, bus width, offset width.
// Assumes a byte-addressed bus whose registers sit on 4-byte boundaries.
package rstc_pkg;
    localparam int REG_W  = 32;
    localparam int BUS_W  = 2 * REG_W;
    localparam int ADDR_W = 8;
endpackage

// File: rtl/reset_bank_line_sync.sv
// One line's round trip: the hold request enters the target domain through two
// flops, and the line value there returns to clk through two more flops.
// Assumes rst_n is held low for at least two edges of each running domain clock.
module reset_bank_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic dom_clk,
    input  logic req_hold,
    output logic line_hold,
    output logic ack_held
);
    logic [1:0] dom_q;
    logic [1:0] back_q;

    // Target domain: bring the hold request over; it comes up held
    always_ff @(posedge dom_clk) begin
        if (!rst_n) dom_q <= 2'b11;
        else        dom_q <= {dom_q[0], req_hold};
    end

    assign line_hold = dom_q[1];

    // Register domain: bring the line state back as the confirmation
    always_ff @(posedge clk) begin
        if (!rst_n) back_q <= 2'b11;
        else        back_q <= {back_q[0], line_hold};
    end

    assign ack_held = back_q[1];
endmodule

// File: rtl/reset_bank_regs.sv
// Register file: holds the hold words, forms status words from the confirmed
// line states and the polarity mask, and returns read data one cycle later.
// A wide access covers the slot at req_addr and the slot after it.
module reset_bank_regs
    import rstc_pkg::*;
#(
    parameter int                   NUM_LINES = 128,
    parameter logic [NUM_LINES-1:0] POL_MASK  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_wide,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [BUS_W-1:0]     req_wdata,
    input  logic [NUM_LINES-1:0] ack_held,
    output logic [NUM_LINES-1:0] hold_q,
    output logic                 rd_valid,
    output logic [BUS_W-1:0]     rd_data
);
    localparam int NUM_WORDS = NUM_LINES / REG_W;
    localparam int SLOT_W    = ADDR_W - 2 + 1;

    logic [SLOT_W-1:0]    slot_lo;
    logic [SLOT_W-1:0]    slot_hi;
    logic [NUM_LINES-1:0] stat_vec;
    logic [REG_W-1:0]     rd_lo;
    logic [REG_W-1:0]     rd_hi;
    logic                 rd_req;

    assign slot_lo  = {1'b0, req_addr[ADDR_W-1:2]};
    assign slot_hi  = slot_lo + 1'b1;
    assign stat_vec = ~ack_held ^ POL_MASK;
    assign rd_req   = req_valid && !req_write;

    // Select the words addressed by the low and high slots
    always_comb begin
        rd_lo = '0;
        rd_hi = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (slot_lo == SLOT_W'(w))             rd_lo = hold_q[w*REG_W +: REG_W];
            if (slot_lo == SLOT_W'(NUM_WORDS + w)) rd_lo = stat_vec[w*REG_W +: REG_W];
            if (slot_hi == SLOT_W'(w))             rd_hi = hold_q[w*REG_W +: REG_W];
            if (slot_hi == SLOT_W'(NUM_WORDS + w)) rd_hi = stat_vec[w*REG_W +: REG_W];
        end
    end

    // Hold words: all held at reset, each loaded from its half of the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '1;
        end else if (req_valid && req_write) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (slot_lo == SLOT_W'(w))
                    hold_q[w*REG_W +: REG_W] <= req_wdata[REG_W-1:0];
                if (req_wide && slot_hi == SLOT_W'(w))
                    hold_q[w*REG_W +: REG_W] <= req_wdata[BUS_W-1:REG_W];
            end
        end
    end

    // Read return: one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= {rd_hi & {REG_W{req_wide}}, rd_lo};
        end
    end
endmodule

// File: rtl/reset_bank_ctrl.sv
// Top of the reset bank: register file plus one round-trip synchronizer per line.
// Assumes NUM_LINES is a multiple of the 32-bit register width.
module reset_bank_ctrl
    import rstc_pkg::*;
#(
    parameter int                   NUM_LINES = 128,
    parameter logic [NUM_LINES-1:0] POL_MASK  =
        128'h0000_0000_0000_2000_0000_0100_0002_0004
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] dom_clk,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_wide,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [BUS_W-1:0]     req_wdata,
    output logic                 rd_valid,
    output logic [BUS_W-1:0]     rd_data,
    output logic [NUM_LINES-1:0] line_rst
);
    logic [NUM_LINES-1:0] hold_q;
    logic [NUM_LINES-1:0] ack_held;

    reset_bank_regs #(
        .NUM_LINES (NUM_LINES),
        .POL_MASK  (POL_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wide  (req_wide),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ack_held  (ack_held),
        .hold_q    (hold_q),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        reset_bank_line_sync u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .dom_clk   (dom_clk[i]),
            .req_hold  (hold_q[i]),
            .line_hold (line_rst[i]),
            .ack_held  (ack_held[i])
        );
    end
endmodule

// File: rtl/reset_bank_ctrl_chk.sv
// Bus and hold-word properties of the reset bank, bound to the top module.
module reset_bank_ctrl_chk
    import rstc_pkg::*;
#(
    parameter int NUM_LINES = 128
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic                 req_wide,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [BUS_W-1:0]     req_wdata,
    input logic                 rd_valid,
    input logic [BUS_W-1:0]     rd_data,
    input logic [NUM_LINES-1:0] hold_q
);
    localparam int NUM_WORDS = NUM_LINES / REG_W;
    localparam logic [ADDR_W-1:0] STAT_BASE = ADDR_W'(NUM_WORDS * 4);
    localparam logic [ADDR_W-1:0] MAP_END   = ADDR_W'(NUM_WORDS * 8);

    AST_RESET_ALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&hold_q)); // R1
    AST_WORD0_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_wide && req_addr == '0)
        |=> hold_q[REG_W-1:0] == $past(req_wdata[REG_W-1:0])); // R2
    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_wide && req_addr >= STAT_BASE && req_addr < MAP_END)
        |=> $stable(hold_q)); // R7
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr >= MAP_END) |=> rd_data == '0); // R8
    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid); // R11
    AST_NO_EXTRA_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid); // R11
endmodule

bind reset_bank_ctrl reset_bank_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_wide  (req_wide),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .hold_q    (hold_q)
);

// File: tb/reset_bank_ctrl_bench.sv
module reset_bank_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 128;
    localparam logic [NL-1:0] POL = 128'h0000_0000_0000_2000_0000_0100_0002_0004;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] dom_en = '1;
    logic [NL-1:0] dom_clk;
    logic          req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [7:0]    req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          rd_valid;
    logic [63:0]   rd_data;
    logic [NL-1:0] line_rst;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    string tag = "R1";

    // Reference model state
    logic [NL-1:0] m_hold, m_l1, m_l2, m_s1, m_s2;
    logic          exp_rvalid = 1'b0;
    logic [63:0]   exp_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign dom_clk = {NL{clk}} & dom_en;

    reset_bank_ctrl u_reset_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .dom_clk(dom_clk),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .line_rst(line_rst)
    );

    function automatic logic [31:0] m_word(input int slot);
        logic [NL-1:0] st;
        st = ~m_s2 ^ POL;
        if (slot < 4)      return m_hold[slot*32 +: 32];
        else if (slot < 8) return st[(slot-4)*32 +: 32];
        else               return 32'h0;
    endfunction

    task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // Model: effects of each clk edge, evaluated just after it
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            m_hold = '1; m_l1 = '1; m_l2 = '1; m_s1 = '1; m_s2 = '1;
            exp_rvalid = 1'b0;
        end else begin
            int s;
            s = int'(req_addr[7:2]);
            exp_rvalid = req_valid && !req_write;
            if (exp_rvalid)
                exp_rdata = {req_wide ? m_word(s + 1) : 32'h0, m_word(s)};
            m_s2 = m_s1;
            m_s1 = m_l2;
            for (int i = 0; i < NL; i++)
                if (dom_en[i]) begin
                    m_l2[i] = m_l1[i];
                    m_l1[i] = m_hold[i];
                end
            if (req_valid && req_write) begin
                if (s < 4) m_hold[s*32 +: 32] = req_wdata[31:0];
                if (req_wide && s + 1 < 4) m_hold[(s+1)*32 +: 32] = req_wdata[63:32];
            end
        end
    end

    // Every-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 line_rst timing", {64'h0, line_rst[63:0]}, {64'h0, m_l2[63:0]});
            chk("R3 line_rst timing", {64'h0, line_rst[127:64]}, {64'h0, m_l2[127:64]});
            chk("R11 rd_valid", {63'h0, rd_valid}, {63'h0, exp_rvalid});
            if (exp_rvalid) chk({tag, " R4 read data vs model"}, rd_data, exp_rdata);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic wide);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wide = wide; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic wide, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_wide = wide; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_wide = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [63:0] d;
        int polls;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1: everything held after reset
        tag = "R1";
        chk("R1 lines held", {64'h0, line_rst[63:0] & line_rst[127:64]}, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF});
        rd(8'h00, 1'b1, d); chk("R1 R9 hold words 0/1", d, 64'hFFFF_FFFF_FFFF_FFFF);
        // R5: status words after reset, reversed lines read 1
        rd(8'h10, 1'b0, d); chk("R5 status0 after reset", d, 64'h0000_0000_0002_0004);
        rd(8'h14, 1'b0, d); chk("R5 status1 after reset", d, 64'h0000_0000_0000_0100);
        rd(8'h18, 1'b0, d); chk("R5 status2 after reset", d, 64'h0000_0000_0000_2000);
        rd(8'h1C, 1'b0, d); chk("R5 status3 after reset", d, 64'h0);

        // R2/R4: release a whole word
        tag = "R2";
        wr(8'h00, 64'h0, 1'b0);
        idle(6);
        chk("R2 word0 lines released", {32'h0, line_rst[31:0]}, 64'h0);
        rd(8'h10, 1'b0, d); chk("R4 R5 status0 released", d, 64'h0000_0000_FFFD_FFFB);

        // Mixed pattern in a word with a reversed line
        wr(8'h04, 64'h0000_0F0F, 1'b0);
        idle(6);
        chk("R2 word1 lines", {32'h0, line_rst[63:32]}, 64'h0000_0F0F);
        rd(8'h04, 1'b0, d); chk("R10 word1 readback", d, 64'h0000_0F0F);
        rd(8'h14, 1'b0, d); chk("R4 R5 status1 mixed", d, 64'h0000_0000_FFFF_F1F0);

        // R9: wide write and read
        tag = "R9";
        wr(8'h08, 64'hA5A5_0000_0000_FFFF, 1'b1);
        idle(6);
        chk("R9 wide write lines", {line_rst[127:96], line_rst[95:64]}, 64'hA5A5_0000_0000_FFFF);
        rd(8'h08, 1'b1, d); chk("R9 R10 wide readback", d, 64'hA5A5_0000_0000_FFFF);

        // R7: status writes ignored
        tag = "R7";
        wr(8'h10, 64'hFFFF_FFFF, 1'b0);
        wr(8'h18, 64'h0, 1'b0);
        idle(6);
        rd(8'h00, 1'b1, d); chk("R7 hold words 0/1 unchanged", d, 64'h0000_0F0F_0000_0000);
        rd(8'h08, 1'b1, d); chk("R7 hold words 2/3 unchanged", d, 64'hA5A5_0000_0000_FFFF);
        chk("R7 word0 lines unchanged", {32'h0, line_rst[31:0]}, 64'h0);

        // R8: unmapped offsets
        tag = "R8";
        wr(8'h20, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        rd(8'h20, 1'b1, d); chk("R8 unmapped read 0x20", d, 64'h0);
        rd(8'h3C, 1'b0, d); chk("R8 unmapped read 0x3C", d, 64'h0);
        idle(6);
        rd(8'h00, 1'b1, d); chk("R8 hold words unchanged", d, 64'h0000_0F0F_0000_0000);
        chk("R8 lines unchanged", {32'h0, line_rst[31:0]}, 64'h0);

        // R6: gated domain clock on line 5
        tag = "R6";
        @(negedge clk); dom_en[5] = 1'b0;
        wr(8'h00, 64'h20, 1'b0);
        idle(10);
        chk("R6 gated line stays released", {63'h0, line_rst[5]}, 64'h0);
        rd(8'h10, 1'b0, d); chk("R6 gated status unchanged", d, 64'h0000_0000_FFFD_FFFB);
        @(negedge clk); dom_en[5] = 1'b1;
        idle(6);
        chk("R6 line held after clock resumes", {63'h0, line_rst[5]}, 64'h1);
        rd(8'h10, 1'b0, d); chk("R6 status confirms after resume", d, 64'h0000_0000_FFFD_FFDB);

        // R12: hold then release on line 96, polling status
        tag = "R12";
        wr(8'h0C, 64'hA5A5_0001, 1'b0);
        polls = 0;
        do begin rd(8'h1C, 1'b0, d); polls++; end while (d[0] !== 1'b0 && polls < 20);
        chk("R12 hold confirmed", {63'h0, d[0]}, 64'h0);
        chk("R12 line held", {63'h0, line_rst[96]}, 64'h1);
        wr(8'h0C, 64'hA5A5_0000, 1'b0);
        polls = 0;
        do begin rd(8'h1C, 1'b0, d); polls++; end while (d[0] !== 1'b1 && polls < 20);
        chk("R12 release confirmed", {63'h0, d[0]}, 64'h1);
        chk("R12 line released", {63'h0, line_rst[96]}, 64'h0);

        idle(2);
        done = 1'b1;
        finish_run();
    end
endmodule